// File: doc/BRIEF.md
# TLB Control Register Write Filter

This block holds three registers that software uses to manage a translation lookaside buffer: a slot-pointer register, a reserved-slot count register and a page-size mask register. Every software write passes through a legality filter. A write that carries a value the block cannot represent is dropped and the register keeps its value. The value is never trimmed to fit.

A mode input selects one of two rule sets. Legacy rules wrap the reserved-slot count modulo the entry count and accept any page-size mask. Strict rules reject an out-of-range count and any page-size mask that is not one of the supported sizes. The entry count is a parameter and need not be a power of two. The number of page-offset bits is also a parameter.

Top module: `tlb_ctl_wfilter`

## Requirements
- R1: After reset, `indexReg`, `wiredReg` and `pageMaskReg` all read zero.
- R2: A write with `wrSel` = 0 loads `wrData[30:0]` into `indexReg[30:0]` when that field is below ENTRIES.
- R3: A `wrSel` = 0 write whose `wrData[30:0]` is ENTRIES or more leaves all 32 bits of `indexReg` unchanged.
- R4: With `newRev` = 0, an accepted `wrSel` = 0 write keeps the previous value of `indexReg[31]` (the probe flag).
- R5: With `newRev` = 1, an accepted `wrSel` = 0 write sets `indexReg[31]` to the old flag ORed with `wrData[31]`. No write ever clears the flag.
- R6: With `newRev` = 0, a `wrSel` = 1 write stores `wrData` modulo ENTRIES in `wiredReg`.
- R7: With `newRev` = 1, a `wrSel` = 1 write stores `wrData` only when it is below ENTRIES. Otherwise `wiredReg` is unchanged.
- R8: With `newRev` = 1, a `wrSel` = 2 write is accepted when `wrData >> (PAGE_SHIFT+1)` equals one of 0x0, 0x3, 0xF, 0x3F, 0xFF, 0x3FF, 0xFFF, 0x3FFF or 0xFFFF. It stores `wrData & 0x1FFFFFFF` with bits PAGE_SHIFT:0 cleared. With the defaults this mask is 0x1FFFE000.
- R9: With `newRev` = 1, a `wrSel` = 2 write of all ones is accepted with the same masking. Any other field value leaves `pageMaskReg` unchanged.
- R10: With `newRev` = 0, every `wrSel` = 2 write is accepted with the masking of R8.
- R11: A cycle with `wrEn` = 0, or with `wrSel` = 3, changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one cycle |
| wrSel | input | 2 | Register select: 0 slot pointer, 1 reserved count, 2 page mask, 3 unused |
| wrData | input | 32 | Write value |
| newRev | input | 1 | 1 selects strict rules, 0 selects legacy rules |
| indexReg | output | 32 | Probe flag in bit 31, slot pointer in bits 30:0 |
| wiredReg | output | 32 | Reserved-slot count |
| pageMaskReg | output | 32 | Page-size mask |

## Verification
The assertions assume that `wrEn`, `wrSel`, `wrData` and `newRev` carry known values at every rising edge after reset. They also assume that the mode applying to a write is the value present in that write's cycle, so the mode may change from one write to the next. The stimulus changes inputs only on falling edges. It switches `newRev` between writes to the same register, so both rule sets act on shared state, including a probe flag that is set under strict rules and then kept by legacy writes.

// File: rtl/tlbwf_pkg.sv
package tlbwf_pkg;

  typedef enum logic [1:0] {
    SEL_INDEX  = 2'd0,
    SEL_WIRED  = 2'd1,
    SEL_PGMASK = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic idxLoad;
    logic idxMergeFlag;
    logic wiredLoad;
    logic wiredWrap;
    logic pmLoad;
  } wrStrobe_t;

endpackage

// File: rtl/tlbwf_ctrl.sv
module tlbwf_ctrl
  import tlbwf_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic        wrEn,
  input  regSel_e     wrSel,
  input  logic [31:0] wrData,
  input  logic        newRev,
  output wrStrobe_t   strobe
);

  localparam int          FIELD_LSB = PAGE_SHIFT + 1;
  localparam int          FIELD_W   = 32 - FIELD_LSB;
  localparam int          NUM_PAT   = 9;
  localparam logic [31:0] ENT_V     = 32'(ENTRIES);

  logic [FIELD_W-1:0] pmField;
  logic [NUM_PAT-1:0] patHit;
  logic               idxInRange;
  logic               wiredInRange;
  logic               allOnes;
  logic               pmLegal;

  assign pmField = wrData[31:FIELD_LSB];

  // Supported page sizes grow by a factor of four: 2^(2k)-1 in the field
  for (genvar k = 0; k < NUM_PAT; k++) begin : g_pat
    localparam logic [63:0]        PAT64 = (64'd1 << (2 * k)) - 64'd1;
    localparam logic [FIELD_W-1:0] PAT   = PAT64[FIELD_W-1:0];
    assign patHit[k] = (pmField == PAT);
  end

  assign idxInRange   = ({1'b0, wrData[30:0]} < ENT_V);
  assign wiredInRange = (wrData < ENT_V);
  assign allOnes      = &wrData;
  assign pmLegal      = !newRev || allOnes || (|patHit);

  always_comb begin
    strobe              = '0;
    strobe.idxMergeFlag = newRev;
    strobe.wiredWrap    = !newRev;
    if (wrEn) begin
      unique case (wrSel)
        SEL_INDEX:  strobe.idxLoad   = idxInRange;
        SEL_WIRED:  strobe.wiredLoad = !newRev || wiredInRange;
        SEL_PGMASK: strobe.pmLoad    = pmLegal;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/tlbwf_dpath.sv
module tlbwf_dpath
  import tlbwf_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  wrStrobe_t   strobe,
  input  logic [31:0] wrData,
  output logic [31:0] indexReg,
  output logic [31:0] wiredReg,
  output logic [31:0] pageMaskReg
);

  localparam logic [31:0] ENT_V   = 32'(ENTRIES);
  localparam logic [31:0] LOW_CLR = (32'd1 << (PAGE_SHIFT + 1)) - 32'd1;
  localparam logic [31:0] PM_KEEP = 32'h1FFF_FFFF & ~LOW_CLR;

  logic [31:0] idxNext;
  logic [31:0] wiredNext;

  assign idxNext   = {indexReg[31] | (strobe.idxMergeFlag & wrData[31]), wrData[30:0]};
  assign wiredNext = strobe.wiredWrap ? (wrData % ENT_V) : wrData;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      indexReg    <= '0;
      wiredReg    <= '0;
      pageMaskReg <= '0;
    end else begin
      if (strobe.idxLoad)   indexReg    <= idxNext;
      if (strobe.wiredLoad) wiredReg    <= wiredNext;
      if (strobe.pmLoad)    pageMaskReg <= wrData & PM_KEEP;
    end
  end

endmodule

// File: rtl/tlb_ctl_wfilter.sv
module tlb_ctl_wfilter
  import tlbwf_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int PAGE_SHIFT = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wrEn,
  input  logic [1:0]  wrSel,
  input  logic [31:0] wrData,
  input  logic        newRev,
  output logic [31:0] indexReg,
  output logic [31:0] wiredReg,
  output logic [31:0] pageMaskReg
);

  wrStrobe_t strobe;

  tlbwf_ctrl #(.ENTRIES(ENTRIES), .PAGE_SHIFT(PAGE_SHIFT)) ctrl_i (
    .wrEn   (wrEn),
    .wrSel  (regSel_e'(wrSel)),
    .wrData (wrData),
    .newRev (newRev),
    .strobe (strobe)
  );

  tlbwf_dpath #(.ENTRIES(ENTRIES), .PAGE_SHIFT(PAGE_SHIFT)) dpath_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .wrData      (wrData),
    .indexReg    (indexReg),
    .wiredReg    (wiredReg),
    .pageMaskReg (pageMaskReg)
  );

endmodule

// File: rtl/tlbwf_chk.sv
module tlbwf_chk #(
  parameter int ENTRIES    = 16,
  parameter int PAGE_SHIFT = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wrEn,
  input logic [1:0]  wrSel,
  input logic        newRev,
  input logic [31:0] indexReg,
  input logic [31:0] wiredReg,
  input logic [31:0] pageMaskReg
);

  localparam logic [31:0] ENT_V   = 32'(ENTRIES);
  localparam logic [31:0] LOW_CLR = (32'd1 << (PAGE_SHIFT + 1)) - 32'd1;
  localparam logic [31:0] PM_KEEP = 32'h1FFF_FFFF & ~LOW_CLR;

  // R2
  idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, indexReg[30:0]} < ENT_V);

  // R7
  wired_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wiredReg < ENT_V);

  // R8
  pm_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pageMaskReg & ~PM_KEEP) == 32'd0);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wrEn || wrSel == 2'd3) |=> ($stable(indexReg) && $stable(wiredReg) && $stable(pageMaskReg)));

  // R4
  flag_legacy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrSel == 2'd0 && !newRev) |=> $stable(indexReg[31]));

  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    indexReg[31] |=> indexReg[31]);

endmodule

bind tlb_ctl_wfilter tlbwf_chk #(.ENTRIES(ENTRIES), .PAGE_SHIFT(PAGE_SHIFT)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wrEn        (wrEn),
  .wrSel       (wrSel),
  .newRev      (newRev),
  .indexReg    (indexReg),
  .wiredReg    (wiredReg),
  .pageMaskReg (pageMaskReg)
);

// File: tb/tlb_ctl_wfilter_tb_top.sv
module tlb_ctl_wfilter_tb_top;

  localparam int ENTRIES    = 16;
  localparam int PAGE_SHIFT = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrSel = 2'd0;
  logic [31:0] wrData = 32'd0;
  logic        newRev = 1'b0;
  logic [31:0] indexReg, wiredReg, pageMaskReg;

  logic [31:0] mIdx = 32'd0, mWired = 32'd0, mPm = 32'd0;
  int          nChecks = 0, nFails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  tlb_ctl_wfilter #(.ENTRIES(ENTRIES), .PAGE_SHIFT(PAGE_SHIFT)) dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .newRev(newRev), .indexReg(indexReg), .wiredReg(wiredReg), .pageMaskReg(pageMaskReg)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(tag, "indexReg", indexReg, mIdx);
    check(tag, "wiredReg", wiredReg, mWired);
    check(tag, "pageMaskReg", pageMaskReg, mPm);
  endtask

  // Reference model: behavioural rules per register
  task automatic modelWrite(input bit en, input int sel, input logic [31:0] d, input bit mode);
    longint unsigned v = d;
    longint unsigned field;
    bit legal;
    if (!en) return;
    if (sel == 0) begin
      if ((v & 64'h7FFF_FFFF) < ENTRIES)
        mIdx = {mIdx[31] | (mode & d[31]), d[30:0]};
    end else if (sel == 1) begin
      if (mode) begin
        if (v < ENTRIES) mWired = d;
      end else begin
        mWired = 32'(v % ENTRIES);
      end
    end else if (sel == 2) begin
      field = v >> (PAGE_SHIFT + 1);
      legal = !mode || (d == 32'hFFFF_FFFF);
      for (int k = 0; k < 9; k++)
        if (field == (64'd1 << (2 * k)) - 1) legal = 1'b1;
      if (legal)
        mPm = 32'(v & 64'h1FFF_FFFF & ~((64'd1 << (PAGE_SHIFT + 1)) - 1));
    end
  endtask

  // Starts and ends on a falling edge
  task automatic op(input bit en, input int sel, input logic [31:0] d, input bit mode, input string tag);
    wrEn = en; wrSel = 2'(sel); wrData = d; newRev = mode;
    @(posedge clk);
    modelWrite(en, sel, d, mode);
    @(negedge clk);
    wrEn = 1'b0;
    compareAll(tag);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compareAll("R1");

    // index register
    op(1, 0, 32'd5,          0, "R2");
    op(1, 0, 32'd16,         0, "R3");
    op(1, 0, 32'h7FFF_FFFF,  1, "R3");
    op(1, 0, 32'h8000_0003,  0, "R4");
    op(1, 0, 32'h8000_000F,  1, "R5");
    op(1, 0, 32'd2,          0, "R4");
    op(1, 0, 32'd1,          1, "R5");
    op(1, 0, 32'h8000_0010,  1, "R3");
    op(1, 0, 32'd15,         1, "R2");

    // wired register
    op(1, 1, 32'd37,         0, "R6");
    op(1, 1, 32'd16,         0, "R6");
    op(1, 1, 32'hFFFF_FFFF,  0, "R6");
    op(1, 1, 32'd15,         1, "R7");
    op(1, 1, 32'd16,         1, "R7");
    op(1, 1, 32'h8000_0000,  1, "R7");
    op(1, 1, 32'd0,          1, "R7");

    // page-mask register
    op(1, 2, 32'h0000_6000,  1, "R8");
    op(1, 2, 32'h1FFF_E000,  1, "R8");
    op(1, 2, 32'h0000_2000,  1, "R9");
    op(1, 2, 32'h3FFF_E000,  1, "R9");
    op(1, 2, 32'h0000_1000,  1, "R8");
    op(1, 2, 32'h01FF_FFFF,  1, "R8");
    op(1, 2, 32'hFFFF_FFFF,  1, "R9");
    op(1, 2, 32'h0000_A000,  1, "R9");
    op(1, 2, 32'h1234_5678,  0, "R10");
    op(1, 2, 32'h0000_2000,  0, "R10");

    // no-effect cycles
    op(1, 3, 32'd7,          0, "R11");
    op(1, 3, 32'hFFFF_FFFF,  1, "R11");
    op(0, 0, 32'd9,          1, "R11");
    op(0, 1, 32'd3,          0, "R11");
    op(0, 2, 32'd0,          1, "R11");

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule